// File: doc/BRIEF.md
# Multi-Channel 16-Bit Timer Counter

This block is a 16-bit up-counter that a system-clock prescaler advances by one step on each selected prescaler tick. Three compare channels (A, B, C) watch the count, and a capture-top register can act as the wrap point. Overflow, the three compare matches and the capture-top match each set an event flag, and each flag reaches its own interrupt line through a mask bit. Software clears the flags with a write-one-to-clear strobe.

There are three waveform modes. In normal counting the counter runs to the maximum and wraps. In the second mode the counter clears when it matches compare A. In the third it clears when it matches the capture-top register. The counter can be loaded by software at any time. A power-reduction input holds the whole timer in its reset state.

Top module: `mtc16_timer`

## Requirements
- R1: While `rst_n` is low, or while `pwr_down` is high, the count is 0, every flag is cleared, every interrupt line is low and the prescaler restarts from 0. A counter write is ignored during this time.
- R2: Clock select is `ctrl_b[2:0]`. The values 0, 6 and 7 halt the counter. The values 1, 2, 3, 4 and 5 advance it once every 1, 8, 64, 256 or 1024 clocks. A free-running 10-bit prescaler produces the step, in the cycle where its low bits (below the divider) are all ones.
- R3: A step from 0xFFFF goes to 0 and sets the overflow flag (bit 0). This holds in every mode in which no top-clear happens on that step.
- R4: In mode 4, a step taken while the count equals compare A loads 0 instead of count+1.
- R5: In mode 12, a step taken while the count equals the capture-top register loads 0 and sets the capture flag (bit 5).
- R6: In every mode, a step taken while the count equals compare A, B or C sets flag bit 1, 2 or 3 respectively.
- R7: A counter write (`cnt_we`) loads `cnt_wdata`, which is visible on the next cycle. The write wins over a step that falls in the same cycle. On the first step after the write, all compare and capture matches and the top-clear are suppressed.
- R8: Flags stay set until software clears them. When `flag_clr_we` is high, each 1 in `flag_clr_data` clears its flag. A flag whose event occurs in the same cycle stays set. Bits 4, 6 and 7 never set.
- R9: Each interrupt line equals its flag ANDed with the `irq_mask` bit at the same position: overflow bit 0, compare A bit 1, compare B bit 2, compare C bit 3, capture bit 5.
- R10: The mode number is {`ctrl_b[4:3]`, `ctrl_a[1:0]`}. Any mode other than 0, 4 and 12 counts as normal mode, with compare events only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down | input | 1 | Power reduction; holds the timer in reset |
| ctrl_a | input | 8 | Control A; bits 1:0 are the low mode bits |
| ctrl_b | input | 8 | Control B; bits 4:3 are the high mode bits, bits 2:0 the clock select |
| cmp_a | input | 16 | Compare A value (top value in mode 4) |
| cmp_b | input | 16 | Compare B value |
| cmp_c | input | 16 | Compare C value |
| cap_top | input | 16 | Capture register value (top value in mode 12) |
| irq_mask | input | 8 | Interrupt mask, laid out like the flags |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_data | input | 8 | Flags to clear (write one to clear) |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write data |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_cmpa | output | 1 | Compare A interrupt |
| irq_cmpb | output | 1 | Compare B interrupt |
| irq_cmpc | output | 1 | Compare C interrupt |
| irq_capt | output | 1 | Capture-top interrupt |
| count | output | 16 | Live count |

## Verification
The bench loads the counter just below 0xFFFF to reach the wrap. A design that skips the overflow flag, or wraps to 1, diverges at once.

In the two clear-on-match modes, it checks that the count never rises past the top value. It then loads the counter with exactly the top value. A design that does not suppress the following match either clears again or raises a spurious flag. A design that suppresses too long misses later matches.

Further tests cover:
- every prescaler division and the halting select values; a wrong tap moves the step cycle;
- an undefined mode value, which must not clear the counter;
- power-down in mid-run;
- write-one-to-clear against masking, so that a design which tangles the flag with its line is caught.

// File: rtl/mtc16_pkg.sv
// Shared constants for the 16-bit timer: mode numbers, clock-select codes
// and the bit positions of the event flags.
package mtc16_pkg;
    localparam int CNT_W   = 16;
    localparam int PRE_W   = 10;
    localparam int FLAG_W  = 8;

    localparam logic [3:0] MODE_NORMAL  = 4'd0;
    localparam logic [3:0] MODE_TOP_A   = 4'd4;
    localparam logic [3:0] MODE_TOP_CAP = 4'd12;

    localparam int FB_OVF  = 0;
    localparam int FB_CMPA = 1;
    localparam int FB_CMPB = 2;
    localparam int FB_CMPC = 3;
    localparam int FB_CAPT = 5;

    localparam logic [FLAG_W-1:0] FLAG_USED = 8'b0010_1111;

    // Number of prescaler low bits that must be all ones for a step; -1 = halted.
    function automatic int sel_to_bits(input logic [2:0] sel);
        case (sel)
            3'd1:    return 0;
            3'd2:    return 3;
            3'd3:    return 6;
            3'd4:    return 8;
            3'd5:    return 10;
            default: return -1;
        endcase
    endfunction
endpackage

// File: rtl/mtc16_prescale.sv
// Free-running prescaler. Produces a one-cycle step enable chosen by the
// clock-select code. Assumes PRE_W is wide enough for the largest divider.
module mtc16_prescale
    import mtc16_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic [2:0] clk_sel,
    output logic       step
);
    logic [PW-1:0] pre_q;
    logic [PW-1:0] tap_mask;

    // Advance the prescaler; restart it on reset or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
    end

    // Build the mask of low bits that must all be ones for a step.
    always_comb begin
        int nb;
        nb = sel_to_bits(clk_sel);
        tap_mask = '0;
        for (int i = 0; i < PW; i++) begin
            if (i < nb) tap_mask[i] = 1'b1;
        end
    end

    // Step when a real divider is selected and the low bits are all ones.
    assign step = !hold && (sel_to_bits(clk_sel) >= 0) && ((pre_q & tap_mask) == tap_mask);

    AST_NO_STEP_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == 3'd0 || clk_sel == 3'd6 || clk_sel == 3'd7) |-> !step); // R2
endmodule

// File: rtl/mtc16_count.sv
// Counter core: increments on a step, clears at the mode's top value, wraps
// at the maximum, accepts a software load and masks matches on the step after it.
// Assumes the step enable is a single-cycle pulse from the prescaler.
module mtc16_count
    import mtc16_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int FW = FLAG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          step,
    input  logic [3:0]    mode,
    input  logic [W-1:0]  cmp_a,
    input  logic [W-1:0]  cmp_b,
    input  logic [W-1:0]  cmp_c,
    input  logic [W-1:0]  cap_top,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  count,
    output logic [FW-1:0] events
);
    logic [W-1:0] cnt_q;
    logic         mask_q;
    logic         adv;
    logic         live;
    logic         hit_a, hit_b, hit_c, hit_cap;
    logic         top_clr;
    logic         wr_ok;

    assign wr_ok = wr_en && !hold;
    assign adv   = step && !wr_ok && !hold;
    assign live  = adv && !mask_q;

    // Compare the present count against every reference.
    always_comb begin
        hit_a   = (cnt_q == cmp_a);
        hit_b   = (cnt_q == cmp_b);
        hit_c   = (cnt_q == cmp_c);
        hit_cap = (cnt_q == cap_top);
    end

    // Decide the top-clear and the event vector for this cycle.
    always_comb begin
        top_clr = live && (((mode == MODE_TOP_A) && hit_a) ||
                           ((mode == MODE_TOP_CAP) && hit_cap));
        events = '0;
        events[FB_CMPA] = live && hit_a;
        events[FB_CMPB] = live && hit_b;
        events[FB_CMPC] = live && hit_c;
        events[FB_CAPT] = live && (mode == MODE_TOP_CAP) && hit_cap;
        events[FB_OVF]  = adv && !top_clr && (cnt_q == {W{1'b1}});
    end

    // Update the count and the one-step match mask.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q  <= '0;
            mask_q <= 1'b0;
        end else if (wr_ok) begin
            cnt_q  <= wr_data;
            mask_q <= 1'b1;
        end else if (adv) begin
            cnt_q  <= top_clr ? '0 : cnt_q + 1'b1;
            mask_q <= 1'b0;
        end
    end

    assign count = cnt_q;

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_en && !hold) |=> $stable(count)); // R2
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hold) |=> (count == $past(wr_data))); // R7
    AST_TOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (top_clr && !hold) |=> (count == '0)); // R4
    AST_MAX_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (events[FB_OVF] && !hold) |=> (count == '0)); // R3
endmodule

// File: rtl/mtc16_flags.sv
// Event flag bank: sticky flags with write-one-to-clear, gated onto request
// lines by a mask. Assumes a set and a clear in the same cycle keep the flag.
module mtc16_flags
    import mtc16_pkg::*;
#(
    parameter int              FW   = FLAG_W,
    parameter logic [FW-1:0]   USED = FLAG_USED
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic [FW-1:0] set_ev,
    input  logic          clr_we,
    input  logic [FW-1:0] clr_bits,
    input  logic [FW-1:0] mask,
    output logic [FW-1:0] lines
);
    logic [FW-1:0] flag_q;

    for (genvar i = 0; i < FW; i++) begin : g_bit
        if (USED[i]) begin : g_used
            // Keep, set or clear one flag bit.
            always_ff @(posedge clk) begin
                if (!rst_n || hold)            flag_q[i] <= 1'b0;
                else if (set_ev[i])            flag_q[i] <= 1'b1;
                else if (clr_we && clr_bits[i]) flag_q[i] <= 1'b0;
            end
        end else begin : g_unused
            assign flag_q[i] = 1'b0;
        end
    end

    assign lines = flag_q & mask;

    AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_ev & USED) && !hold) |=> ((flag_q & $past(set_ev & USED)) == $past(set_ev & USED))); // R8
endmodule

// File: rtl/mtc16_timer.sv
// Top of the 16-bit timer: builds the mode number, wires the prescaler,
// counter core and flag bank, and fans the flag lines out to the request pins.
// Assumes all register inputs are already synchronous to clk.
module mtc16_timer
    import mtc16_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pwr_down,
    input  logic [7:0]  ctrl_a,
    input  logic [7:0]  ctrl_b,
    input  logic [15:0] cmp_a,
    input  logic [15:0] cmp_b,
    input  logic [15:0] cmp_c,
    input  logic [15:0] cap_top,
    input  logic [7:0]  irq_mask,
    input  logic        flag_clr_we,
    input  logic [7:0]  flag_clr_data,
    input  logic        cnt_we,
    input  logic [15:0] cnt_wdata,
    output logic        irq_ovf,
    output logic        irq_cmpa,
    output logic        irq_cmpb,
    output logic        irq_cmpc,
    output logic        irq_capt,
    output logic [15:0] count
);
    logic [3:0]        mode;
    logic              step;
    logic [FLAG_W-1:0] ev;
    logic [FLAG_W-1:0] lines;

    assign mode = {ctrl_b[4:3], ctrl_a[1:0]};

    mtc16_prescale #(.PW(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .hold(pwr_down),
        .clk_sel(ctrl_b[2:0]), .step(step)
    );

    mtc16_count #(.W(CNT_W), .FW(FLAG_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(pwr_down), .step(step), .mode(mode),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .cap_top(cap_top),
        .wr_en(cnt_we), .wr_data(cnt_wdata), .count(count), .events(ev)
    );

    mtc16_flags #(.FW(FLAG_W), .USED(FLAG_USED)) u_flg (
        .clk(clk), .rst_n(rst_n), .hold(pwr_down), .set_ev(ev),
        .clr_we(flag_clr_we), .clr_bits(flag_clr_data), .mask(irq_mask),
        .lines(lines)
    );

    assign irq_ovf  = lines[FB_OVF];
    assign irq_cmpa = lines[FB_CMPA];
    assign irq_cmpb = lines[FB_CMPB];
    assign irq_cmpc = lines[FB_CMPC];
    assign irq_capt = lines[FB_CAPT];

    AST_PWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (!irq_ovf && !irq_cmpa && !irq_cmpb && !irq_cmpc && !irq_capt && count == 16'd0)); // R1
endmodule

// File: tb/mtc16_timer_test.sv
module mtc16_timer_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_down = 1'b0;
    logic [7:0]  ctrl_a = '0, ctrl_b = '0, irq_mask = '0, flag_clr_data = '0;
    logic [15:0] cmp_a = '0, cmp_b = '0, cmp_c = '0, cap_top = '0, cnt_wdata = '0;
    logic        flag_clr_we = 1'b0, cnt_we = 1'b0;
    logic        irq_ovf, irq_cmpa, irq_cmpb, irq_cmpc, irq_capt;
    logic [15:0] count;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // Reference model state.
    int m_pre = 0;
    int m_cnt = 0;
    bit m_mask = 0;
    int m_flags = 0;

    mtc16_timer uut (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c), .cap_top(cap_top),
        .irq_mask(irq_mask), .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .irq_ovf(irq_ovf), .irq_cmpa(irq_cmpa),
        .irq_cmpb(irq_cmpb), .irq_cmpc(irq_cmpc), .irq_capt(irq_capt), .count(count)
    );

    always #(PERIOD/2) clk = ~clk;

    // Behavioural model of the requirements, advanced on each rising edge.
    always @(posedge clk) begin
        int div, ev, mode;
        bit stp, clr;
        if (!rst_n || pwr_down) begin
            m_pre = 0; m_cnt = 0; m_mask = 0; m_flags = 0;
        end else begin
            case (ctrl_b[2:0])
                1: div = 1; 2: div = 8; 3: div = 64; 4: div = 256; 5: div = 1024;
                default: div = 0;
            endcase
            stp  = (div != 0) && ((m_pre % div) == div - 1);
            mode = {ctrl_b[4:3], ctrl_a[1:0]};
            ev = 0;
            if (cnt_we) begin
                m_cnt = cnt_wdata; m_mask = 1;
            end else if (stp) begin
                clr = 0;
                if (!m_mask) begin
                    if (m_cnt == cmp_a) ev |= 2;
                    if (m_cnt == cmp_b) ev |= 4;
                    if (m_cnt == cmp_c) ev |= 8;
                    if (mode == 12 && m_cnt == cap_top) begin ev |= 32; clr = 1; end
                    if (mode == 4 && m_cnt == cmp_a) clr = 1;
                end
                if (clr) m_cnt = 0;
                else if (m_cnt == 65535) begin m_cnt = 0; ev |= 1; end
                else m_cnt = m_cnt + 1;
                m_mask = 0;
            end
            if (flag_clr_we) m_flags = m_flags & ~int'(flag_clr_data);
            m_flags = (m_flags | ev) & 8'h2F;
            m_pre = (m_pre + 1) % 1024;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model away from the rising edge.
    always @(negedge clk) begin
        int lines;
        lines = m_flags & int'(irq_mask);
        check(cur_req, "count", int'(count), m_cnt);
        check(cur_req, "irq lines (R9)",
              int'({irq_capt, 1'b0, irq_cmpc, irq_cmpb, irq_cmpa, irq_ovf}), lines);
    end

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic load_cnt(int v);
        cnt_we = 1; cnt_wdata = 16'(v);
        idle(1);
        cnt_we = 0;
    endtask

    task automatic clear_flags(int m);
        flag_clr_we = 1; flag_clr_data = 8'(m);
        idle(1);
        flag_clr_we = 0;
    endtask

    initial begin
        #(PERIOD * 190000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int peak;
        idle(3);
        check("R1", "reset count", int'(count), 0);
        rst_n = 1;
        idle(2);
        // R2 halted select: a load holds
        cur_req = "R2"; irq_mask = 8'hFF;
        load_cnt(16'h1234);
        idle(10);
        check("R2", "halted count", int'(count), 16'h1234);
        ctrl_b = 8'h06; idle(20);
        ctrl_b = 8'h07; idle(20);
        check("R2", "external select halts", int'(count), 16'h1234);
        // R3 normal wrap and overflow
        cur_req = "R3"; ctrl_b = 8'h01;
        load_cnt(16'hFFF0);
        idle(30);
        check("R3", "overflow line", int'(irq_ovf), 1);
        // R6 compare B/C in normal mode
        cur_req = "R6"; cmp_b = 16'd40; cmp_c = 16'd45; cmp_a = 16'd50;
        load_cnt(0);
        idle(60);
        check("R6", "cmpb line", int'(irq_cmpb), 1);
        check("R6", "cmpc line", int'(irq_cmpc), 1);
        check("R6", "cmpa line", int'(irq_cmpa), 1);
        // R8 write-one-to-clear, R9 masking
        cur_req = "R8"; ctrl_b = 8'h00; idle(2);
        clear_flags(8'h01);
        check("R8", "ovf cleared", int'(irq_ovf), 0);
        check("R8", "cmpb kept", int'(irq_cmpb), 1);
        cur_req = "R9"; irq_mask = 8'h00; idle(2);
        check("R9", "masked cmpb", int'(irq_cmpb), 0);
        irq_mask = 8'hFF; idle(2);
        check("R9", "unmasked cmpb", int'(irq_cmpb), 1);
        clear_flags(8'hFF);
        check("R8", "all cleared", int'(irq_cmpa | irq_cmpb | irq_cmpc | irq_capt), 0);
        // R4 clear on compare A (mode 4 = ctrl_b[4:3]=01, ctrl_a[1:0]=00)
        cur_req = "R4"; cmp_a = 16'd20; ctrl_b = 8'h09; load_cnt(0);
        peak = 0;
        for (int i = 0; i < 100; i++) begin idle(1); if (int'(count) > peak) peak = int'(count); end
        check("R4", "peak below top", peak, 20);
        // R7 load equal to top skips the clear
        cur_req = "R7"; load_cnt(20);
        idle(10);
        check("R7", "ran past top", int'(count > 16'd20), 1);
        // R5 clear on capture top (mode 12 = ctrl_b[4:3]=11)
        cur_req = "R5"; ctrl_b = 8'h00; clear_flags(8'hFF);
        cap_top = 16'd15; ctrl_b = 8'h19; load_cnt(0);
        peak = 0;
        for (int i = 0; i < 100; i++) begin idle(1); if (int'(count) > peak) peak = int'(count); end
        check("R5", "peak below cap top", peak, 15);
        check("R5", "capt line", int'(irq_capt), 1);
        // R10 undefined mode 5 counts through compare A
        cur_req = "R10"; ctrl_a = 8'h01; ctrl_b = 8'h09; load_cnt(0);
        idle(60);
        check("R10", "no clear in mode 5", int'(count > 16'd50), 1);
        ctrl_a = 8'h00;
        // R2 each divider
        cur_req = "R2"; ctrl_b = 8'h02; idle(200);
        ctrl_b = 8'h03; idle(700);
        ctrl_b = 8'h04; idle(1500);
        ctrl_b = 8'h05; idle(4200);
        // R1 power-down mid-run
        cur_req = "R1"; ctrl_b = 8'h01; idle(30);
        pwr_down = 1; cnt_we = 1; cnt_wdata = 16'h5555; idle(3);
        cnt_we = 0;
        check("R1", "pwr count", int'(count), 0);
        check("R1", "pwr lines", int'({irq_ovf, irq_cmpa, irq_cmpb, irq_cmpc, irq_capt}), 0);
        pwr_down = 0; idle(40);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule